// File: doc/BRIEF.md
# Destination-Range Uplink Fault Filter

This block sits in the route-computation stage of a switch in an adaptively routed hierarchical network. Before a packet commits to an uplink, the filter removes every uplink whose deterministic downward path toward the packet's destination would pass through a broken downlink. It also removes uplinks that carry hard errors for all traffic. If the uplink the router prefers survives that pruning, the filter keeps it. If not, the filter offers the next surviving uplink in circular order. If nothing survives, it flags that the packet has no route so that the source can retry it.

The filter keeps a small programmable table. Each entry names an inclusive span of destination addresses and a set of uplinks blocked for that span, so one entry covers a whole subtree of destinations. A separate global mask lists the uplinks with hard failures. Both are loaded through plain write strobes. Each lookup returns a registered answer one clock after the request.

Top module: `uplink_fault_filter`

## Requirements
- R1: After reset, `rspValid`, `rspNoRoute` and `rspUplink` are 0, every table entry is invalid and the hard-failure mask is empty, so a lookup returns its preferred uplink whenever that uplink is a candidate.
- R2: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high. In a cycle with no response, `rspNoRoute` and `rspUplink` are 0.
- R3: An uplink whose bit is 1 in the hard-failure mask, which `failWrEn` replaces as a whole with `failWrMask`, is never returned for any destination.
- R4: A table entry blocks the uplinks set in its mask only when its valid bit is 1 and `tblWrBase <= reqDest <= tblWrLimit`, with both bounds inclusive. An entry whose base exceeds its limit blocks nothing. An invalid entry blocks nothing.
- R5: When several valid entries contain the destination, the union of their masks is blocked.
- R6: If uplink `reqPref` is a candidate (bit set in `reqCand`) and is neither hard-failed nor blocked, the response is `reqPref`.
- R7: Otherwise the response is the first permitted uplink met when counting upward from `reqPref+1`, wrapping from NUM_UPLINKS-1 to 0.
- R8: If no candidate is permitted, including the case of an empty candidate mask, `rspNoRoute` is 1 and `rspUplink` is 0.
- R9: A table write or hard-failure write in the same cycle as a lookup does not affect that lookup. It does affect the next one.
- R10: Whenever `rspNoRoute` is 0 in a response cycle, `rspUplink` was set in the request's candidate mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Write one table entry |
| tblWrIdx | input | 3 | Entry index to write |
| tblWrValid | input | 1 | Valid bit written to the entry |
| tblWrBase | input | 16 | Lowest destination of the entry (inclusive) |
| tblWrLimit | input | 16 | Highest destination of the entry (inclusive) |
| tblWrBlock | input | 16 | Uplinks blocked for the entry's span |
| failWrEn | input | 1 | Replace the hard-failure mask |
| failWrMask | input | 16 | New hard-failure mask |
| reqValid | input | 1 | Lookup request |
| reqDest | input | 16 | Destination address of the packet |
| reqCand | input | 16 | Candidate uplinks offered by the router |
| reqPref | input | 4 | Preferred uplink index |
| rspValid | output | 1 | Response present |
| rspNoRoute | output | 1 | No permitted uplink remained |
| rspUplink | output | 4 | Chosen uplink |

## Verification
The lookup and the two programming paths can act in the same cycle, so a lookup can see a table or failure mask that is being rewritten under it. The bench forces this case directly. It writes an entry covering all destinations and changes the failure mask in the same cycles as lookups that the new contents would redirect. It also lets random traffic mix writes and lookups freely. A reference model applies each write only after it has computed the answer for that cycle, so the bench judges both the lookup in the write cycle and the lookup after it. It expects the old contents in the first and the new contents in the second.

// File: rtl/ufl_pkg.sv
package ufl_pkg;
  typedef struct packed {
    logic tableWr;
    logic failWr;
    logic lookup;
  } uflStrobe_t;
endpackage

// File: rtl/ufl_ctrl.sv
module ufl_ctrl #(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                           tblWrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] tblWrIdx,
  input  logic                           failWrEn,
  input  logic                           reqValid,
  output ufl_pkg::uflStrobe_t            strobe
);
  localparam int IDXW = $clog2(NUM_ENTRIES);
  localparam logic [IDXW:0] ENT_COUNT = NUM_ENTRIES[IDXW:0];

  logic idxInRange;

  // an index past the last entry is dropped rather than aliased
  assign idxInRange = ({1'b0, tblWrIdx} < ENT_COUNT);

  always_comb begin
    strobe.tableWr = tblWrEn && idxInRange;
    strobe.failWr  = failWrEn;
    strobe.lookup  = reqValid;
  end
endmodule

// File: rtl/ufl_datapath.sv
module ufl_datapath #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_UPLINKS = 16,
  parameter int DEST_W      = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ufl_pkg::uflStrobe_t            strobe,
  input  logic [$clog2(NUM_ENTRIES)-1:0] tblWrIdx,
  input  logic                           tblWrValid,
  input  logic [DEST_W-1:0]              tblWrBase,
  input  logic [DEST_W-1:0]              tblWrLimit,
  input  logic [NUM_UPLINKS-1:0]         tblWrBlock,
  input  logic [NUM_UPLINKS-1:0]         failWrMask,
  input  logic [DEST_W-1:0]              reqDest,
  input  logic [NUM_UPLINKS-1:0]         reqCand,
  input  logic [$clog2(NUM_UPLINKS)-1:0] reqPref,
  output logic                           rspValid,
  output logic                           rspNoRoute,
  output logic [$clog2(NUM_UPLINKS)-1:0] rspUplink
);
  localparam int UPW  = $clog2(NUM_UPLINKS);
  localparam int OFFW = UPW + 1;
  localparam logic [OFFW-1:0] UP_COUNT = NUM_UPLINKS[OFFW-1:0];

  // table state
  logic [DEST_W-1:0]      baseQ  [NUM_ENTRIES];
  logic [DEST_W-1:0]      limitQ [NUM_ENTRIES];
  logic [NUM_UPLINKS-1:0] blockQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_UPLINKS-1:0] failQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      failQ  <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        baseQ[e]  <= '0;
        limitQ[e] <= '0;
        blockQ[e] <= '0;
      end
    end else begin
      if (strobe.tableWr) begin
        baseQ[tblWrIdx]  <= tblWrBase;
        limitQ[tblWrIdx] <= tblWrLimit;
        blockQ[tblWrIdx] <= tblWrBlock;
        validQ[tblWrIdx] <= tblWrValid;
      end
      if (strobe.failWr) begin
        failQ <= failWrMask;
      end
    end
  end

  // range match per entry
  logic [NUM_UPLINKS-1:0] entryBlock [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entryHit;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    assign entryHit[e]   = validQ[e] && (reqDest >= baseQ[e]) && (reqDest <= limitQ[e]);
    assign entryBlock[e] = entryHit[e] ? blockQ[e] : '0;
  end

  logic [NUM_UPLINKS-1:0] blockedAll;
  always_comb begin
    blockedAll = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      blockedAll = blockedAll | entryBlock[e];
    end
  end

  logic [NUM_UPLINKS-1:0] permitted;
  assign permitted = reqCand & ~failQ & ~blockedAll;

  // circular search starting just after the preferred uplink
  logic [2*NUM_UPLINKS-1:0] doubled;
  logic [2*NUM_UPLINKS-1:0] rotWide;
  logic [NUM_UPLINKS-1:0]   rotated;
  logic [OFFW-1:0]          prefNext;
  logic [OFFW-1:0]          hopCount;
  logic [OFFW-1:0]          wrapSum;
  logic                     foundAny;
  logic [UPW-1:0]           pickIdx;
  logic                     noneLeft;

  assign doubled  = {permitted, permitted};
  assign prefNext = {1'b0, reqPref} + OFFW'(1);
  assign rotWide  = doubled >> prefNext;
  assign rotated  = rotWide[NUM_UPLINKS-1:0];

  always_comb begin
    foundAny = 1'b0;
    hopCount = '0;
    for (int i = 0; i < NUM_UPLINKS; i++) begin
      if (!foundAny && rotated[i]) begin
        foundAny = 1'b1;
        hopCount = OFFW'(i);
      end
    end
    wrapSum = prefNext + hopCount;
    if (wrapSum >= UP_COUNT) begin
      wrapSum = wrapSum - UP_COUNT;
    end
  end

  always_comb begin
    noneLeft = !foundAny;
    if (permitted[reqPref]) begin
      pickIdx = reqPref;
    end else if (foundAny) begin
      pickIdx = wrapSum[UPW-1:0];
    end else begin
      pickIdx = '0;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspNoRoute <= 1'b0;
      rspUplink  <= '0;
    end else begin
      rspValid <= strobe.lookup;
      if (strobe.lookup) begin
        rspNoRoute <= noneLeft;
        rspUplink  <= pickIdx;
      end else begin
        rspNoRoute <= 1'b0;
        rspUplink  <= '0;
      end
    end
  end
endmodule

// File: rtl/uplink_fault_filter.sv
module uplink_fault_filter #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_UPLINKS = 16,
  parameter int DEST_W      = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tblWrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] tblWrIdx,
  input  logic                           tblWrValid,
  input  logic [DEST_W-1:0]              tblWrBase,
  input  logic [DEST_W-1:0]              tblWrLimit,
  input  logic [NUM_UPLINKS-1:0]         tblWrBlock,
  input  logic                           failWrEn,
  input  logic [NUM_UPLINKS-1:0]         failWrMask,
  input  logic                           reqValid,
  input  logic [DEST_W-1:0]              reqDest,
  input  logic [NUM_UPLINKS-1:0]         reqCand,
  input  logic [$clog2(NUM_UPLINKS)-1:0] reqPref,
  output logic                           rspValid,
  output logic                           rspNoRoute,
  output logic [$clog2(NUM_UPLINKS)-1:0] rspUplink
);
  ufl_pkg::uflStrobe_t strobe;

  ufl_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) i_ctrl (
    .tblWrEn  (tblWrEn),
    .tblWrIdx (tblWrIdx),
    .failWrEn (failWrEn),
    .reqValid (reqValid),
    .strobe   (strobe)
  );

  ufl_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .NUM_UPLINKS(NUM_UPLINKS),
    .DEST_W     (DEST_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tblWrIdx   (tblWrIdx),
    .tblWrValid (tblWrValid),
    .tblWrBase  (tblWrBase),
    .tblWrLimit (tblWrLimit),
    .tblWrBlock (tblWrBlock),
    .failWrMask (failWrMask),
    .reqDest    (reqDest),
    .reqCand    (reqCand),
    .reqPref    (reqPref),
    .rspValid   (rspValid),
    .rspNoRoute (rspNoRoute),
    .rspUplink  (rspUplink)
  );
endmodule

// File: rtl/ufl_checker.sv
module ufl_checker #(
  parameter int NUM_UPLINKS = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           failWrEn,
  input logic [NUM_UPLINKS-1:0]         failWrMask,
  input logic                           reqValid,
  input logic [NUM_UPLINKS-1:0]         reqCand,
  input logic                           rspValid,
  input logic                           rspNoRoute,
  input logic [$clog2(NUM_UPLINKS)-1:0] rspUplink
);
  logic [NUM_UPLINKS-1:0] failShadow;
  logic [NUM_UPLINKS-1:0] snapCand;
  logic [NUM_UPLINKS-1:0] snapFail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failShadow <= '0;
      snapCand   <= '0;
      snapFail   <= '0;
    end else begin
      if (failWrEn) failShadow <= failWrMask;
      if (reqValid) begin
        snapCand <= reqCand;
        snapFail <= failShadow;
      end
    end
  end

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_resp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_noroute_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspNoRoute |-> (rspValid && rspUplink == '0));

  p_empty_cand_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && snapCand == '0) |-> rspNoRoute);

  p_pick_is_cand_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspNoRoute) |-> snapCand[rspUplink]);

  p_pick_not_failed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspNoRoute) |-> !snapFail[rspUplink]);
endmodule

bind uplink_fault_filter ufl_checker #(.NUM_UPLINKS(NUM_UPLINKS)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .failWrEn   (failWrEn),
  .failWrMask (failWrMask),
  .reqValid   (reqValid),
  .reqCand    (reqCand),
  .rspValid   (rspValid),
  .rspNoRoute (rspNoRoute),
  .rspUplink  (rspUplink)
);

// File: tb/test_uplink_fault_filter.sv
`timescale 1ns/1ps
module test_uplink_fault_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [2:0]  tblWrIdx = '0;
  logic        tblWrValid = 1'b0;
  logic [15:0] tblWrBase = '0;
  logic [15:0] tblWrLimit = '0;
  logic [15:0] tblWrBlock = '0;
  logic        failWrEn = 1'b0;
  logic [15:0] failWrMask = '0;
  logic        reqValid = 1'b0;
  logic [15:0] reqDest = '0;
  logic [15:0] reqCand = '0;
  logic [3:0]  reqPref = '0;
  logic        rspValid;
  logic        rspNoRoute;
  logic [3:0]  rspUplink;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uplink_fault_filter i_uplink_fault_filter (
    .clk(clk), .rstN(rstN),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrValid(tblWrValid),
    .tblWrBase(tblWrBase), .tblWrLimit(tblWrLimit), .tblWrBlock(tblWrBlock),
    .failWrEn(failWrEn), .failWrMask(failWrMask),
    .reqValid(reqValid), .reqDest(reqDest), .reqCand(reqCand), .reqPref(reqPref),
    .rspValid(rspValid), .rspNoRoute(rspNoRoute), .rspUplink(rspUplink)
  );

  // reference model state
  logic [15:0] mBase [8];
  logic [15:0] mLim  [8];
  logic [15:0] mMask [8];
  bit          mVal  [8];
  logic [15:0] mFail;

  function automatic void modelLookup(input logic [15:0] dest, input logic [15:0] cand,
                                      input logic [3:0] pref, output bit nr,
                                      output logic [3:0] up);
    logic [15:0] blk = '0;
    logic [15:0] ok;
    for (int e = 0; e < 8; e++)
      if (mVal[e] && dest >= mBase[e] && dest <= mLim[e]) blk |= mMask[e];
    ok = cand & ~mFail & ~blk;
    nr = 1'b0;
    up = '0;
    if (ok == '0) nr = 1'b1;
    else if (ok[pref]) up = pref;
    else begin
      for (int k = 15; k >= 1; k--)
        if (ok[(int'(pref) + k) % 16]) up = 4'((int'(pref) + k) % 16);
    end
  endfunction

  function automatic void note(input bit good, input string req, input string what,
                               input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // one cycle: drive at negedge, compare the registered answer at the next negedge
  task automatic step(input bit look, input logic [15:0] dest, input logic [15:0] cand,
                      input logic [3:0] pref,
                      input bit wr, input logic [2:0] idx, input bit val,
                      input logic [15:0] base, input logic [15:0] lim, input logic [15:0] blk,
                      input bit fw, input logic [15:0] fmask, input string req);
    bit expNr;
    logic [3:0] expUp;
    reqValid = look; reqDest = dest; reqCand = cand; reqPref = pref;
    tblWrEn = wr; tblWrIdx = idx; tblWrValid = val;
    tblWrBase = base; tblWrLimit = lim; tblWrBlock = blk;
    failWrEn = fw; failWrMask = fmask;
    modelLookup(dest, cand, pref, expNr, expUp);
    if (!look) begin expNr = 1'b0; expUp = '0; end
    if (wr) begin mBase[idx] = base; mLim[idx] = lim; mMask[idx] = blk; mVal[idx] = val; end
    if (fw) mFail = fmask;
    @(negedge clk);
    note({rspValid, rspNoRoute, rspUplink} == {look, expNr, expUp}, req, "valid/noroute/uplink",
         int'({rspValid, rspNoRoute, rspUplink}), int'({look, expNr, expUp}));
  endtask

  task automatic look(input logic [15:0] dest, input logic [15:0] cand,
                      input logic [3:0] pref, input string req);
    step(1, dest, cand, pref, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic wrEntry(input logic [2:0] idx, input bit val, input logic [15:0] base,
                         input logic [15:0] lim, input logic [15:0] blk);
    step(0, 0, 0, 0, 1, idx, val, base, lim, blk, 0, 0, "R2");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int e = 0; e < 8; e++) begin mBase[e] = 0; mLim[e] = 0; mMask[e] = 0; mVal[e] = 0; end
    mFail = '0;
    repeat (3) @(negedge clk);
    note({rspValid, rspNoRoute, rspUplink} == 6'd0, "R1", "reset outputs",
         int'({rspValid, rspNoRoute, rspUplink}), 0);
    rstN = 1'b1;

    // R1: empty table and failure mask keep the preferred uplink
    look(16'd40, 16'hFFFF, 4'd5, "R1");
    // R6: preferred uplink kept
    look(16'd7, 16'hFFFF, 4'd9, "R6");
    // R3: hard failure of uplink 9, then R7 next one up
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0200, "R2");
    look(16'd7, 16'hFFFF, 4'd9, "R3");
    // R7: circular wrap from 15 to 3, and forward from 4 to 14
    look(16'd7, 16'h4008, 4'd15, "R7");
    look(16'd7, 16'h4008, 4'd4, "R7");
    // R4: inclusive range bounds
    wrEntry(3'd0, 1, 16'd100, 16'd200, 16'h0008);
    look(16'd100, 16'h0028, 4'd3, "R4");
    look(16'd200, 16'h0028, 4'd3, "R4");
    look(16'd201, 16'h0028, 4'd3, "R4");
    look(16'd99,  16'h0028, 4'd3, "R4");
    // R5: overlapping entries combine
    wrEntry(3'd1, 1, 16'd150, 16'd300, 16'h0020);
    look(16'd160, 16'h00A8, 4'd3, "R5");
    look(16'd250, 16'h00A8, 4'd3, "R5");
    // R8: nothing permitted, and empty candidates
    look(16'd160, 16'h0028, 4'd3, "R8");
    look(16'd500, 16'h0000, 4'd2, "R8");
    // R9: entry write in the lookup cycle, then the next lookup
    step(1, 16'd160, 16'h00A8, 4'd3, 1, 3'd2, 1, 16'd0, 16'hFFFF, 16'h0080, 0, 0, "R9");
    look(16'd160, 16'h00A8, 4'd3, "R9");
    // R9: failure mask write in the lookup cycle
    step(1, 16'd1000, 16'hFFFF, 4'd10, 0, 0, 0, 0, 0, 0, 1, 16'h0600, "R9");
    look(16'd1000, 16'hFFFF, 4'd10, "R9");
    // R4: invalidated entry and inverted range block nothing
    wrEntry(3'd2, 0, 16'd0, 16'hFFFF, 16'h0080);
    look(16'd160, 16'h00A8, 4'd3, "R4");
    wrEntry(3'd3, 1, 16'd500, 16'd400, 16'hFFFF);
    look(16'd450, 16'hFFFF, 4'd0, "R4");
    // R2: idle cycle
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // constrained random mix (R3 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 600; n++) begin
      bit doLook = ($urandom % 4) != 0;
      bit doWr = ($urandom % 5) == 0;
      bit doFail = ($urandom % 25) == 0;
      logic [15:0] base = 16'($urandom % 1024);
      logic [15:0] span = 16'($urandom % 300);
      logic [15:0] lim = (($urandom % 8) == 0) ? base - 16'd1 : base + span;
      step(doLook, 16'($urandom % 1100), 16'($urandom | $urandom), 4'($urandom),
           doWr, 3'($urandom), ($urandom % 6) != 0, base, lim,
           16'($urandom & $urandom & $urandom),
           doFail, 16'($urandom & $urandom & $urandom), "R10");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule